// File: doc/BRIEF.md
# USB Control Endpoint Zero Engine

This block runs the device side of control transfers on endpoint zero of a full-speed USB device core. It sits between a token/packet layer and the register bus of a local microcontroller. The packet layer reports each token with its PID and endpoint number, then streams any payload bytes, then marks the end of the packet. The engine answers with a one-cycle handshake code. For an IN token it also gives the byte count of the packet to send, and the packet layer reads those bytes from the engine's IN buffer.

The eight request bytes of a SETUP stage go into their own small buffer. The data stage uses one buffer for each direction, each as large as a full-speed control packet. Firmware fills and drains these buffers the same way it handles bulk endpoint buffers. The hardware follows the request through its SETUP, optional DATA and STATUS phases. It takes the stage direction and the expected length from the request bytes, and it raises a separate interrupt flag at the end of each phase. Firmware only decodes the request and arms or stalls each response.

Top module: `ep0_ctrl_engine`

## Requirements
- R1: A SETUP token to endpoint 0 followed by exactly 8 bytes stores them in the request buffer, read at register 0x80+i. It produces an ACK handshake (hs_code 0) one cycle after rx_end.
- R2: Tokens addressed to any endpoint other than 0, SETUP included, are ignored. No byte is captured and no handshake is produced.
- R3: Register 0x8D reads {dir, phase}: phase in bits 1:0 (idle 0, receiving request 1, data 2, status 3) and the direction in bit 2, taken from bit 7 of request byte 0. A complete request whose length (bytes 6 and 7, little-endian) is zero goes straight to status. Any other request goes to data. At most one phase event occurs in a cycle.
- R4: In an armed IN data stage, an IN token to endpoint 0 is answered one cycle later with hs_code 3 (data) and tx_len equal to the count written to register 0x8A (clamped to 64). tx_byte shows IN buffer byte tx_addr. The IN buffer is written at registers 0x00-0x3F.
- R5: In an armed OUT data stage, the payload of an OUT packet is stored from register 0x40 upward and its count is kept at register 0x8E. The packet is answered with ACK.
- R6: The data stage ends, and the phase moves to status, on a packet shorter than 64 bytes or when the bytes moved so far reach the request length. A full packet below that length keeps the data phase.
- R7: The status stage runs opposite to the data direction, or IN when there is no data stage. It completes with a zero-length packet (an empty IN reply, or an empty OUT acknowledged). The phase then returns to idle.
- R8: Without an arm (write bit 0 of register 0x89), IN and OUT tokens to endpoint 0 get NAK (hs_code 1), and OUT payload is not stored. Each accepted packet uses up the arm.
- R9: A stall request (write bit 1 of register 0x89) makes every IN or OUT packet on endpoint 0 answer STALL (hs_code 2) until the next SETUP token.
- R10: A SETUP token aborts any transfer in progress. It clears the arm and the stall, and the new request replaces the buffer and the phase.
- R11: The interrupt flags (bit 0 request, bit 1 data stage done, bit 2 status done) are sticky. Register 0x88 reads them. Writing 1 to a bit of 0x88 clears it, but a flag set by hardware in the same cycle stays set.
- R12: Bit 0 of the endpoint-0 valid registers 0x8B (IN) and 0x8C (OUT) always reads 1 and ignores writes. Bits 7:1 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token strobe |
| tok_pid | input | 2 | Token kind: 0 SETUP, 1 OUT, 2 IN |
| tok_ep | input | 4 | Token endpoint number |
| rx_valid | input | 1 | Payload byte strobe |
| rx_byte | input | 8 | Payload byte |
| rx_end | input | 1 | End of a received payload packet |
| tx_addr | input | 6 | IN buffer read index for the packet layer |
| tx_byte | output | 8 | IN buffer byte at tx_addr |
| hs_valid | output | 1 | Handshake strobe |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL, 3 send data |
| tx_len | output | 7 | Byte count of the IN packet to send |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_setup | output | 1 | Request-received flag |
| irq_data | output | 1 | Data-stage-done flag |
| irq_status | output | 1 | Status-done flag |

## Verification
The interrupt flags are set by the packet side and cleared by firmware writes, so both can reach the same flag bit on one clock edge. The bench forces this by putting a write of 1 to the request bit of register 0x88 in the same cycle as the end of a SETUP packet. A reference model of the flags is compared with the outputs after every edge, and the flag must still be set afterwards. A SETUP token that arrives while firmware has an arm pending is also checked: the arm must be gone, and the next IN token must get NAK.

// File: rtl/ep0_pkg.sv
package ep0_pkg;

  typedef enum logic [1:0] {PID_SETUP = 2'd0, PID_OUT = 2'd1, PID_IN = 2'd2} pid_e;
  typedef enum logic [1:0] {HS_ACK = 2'd0, HS_NAK = 2'd1, HS_STALL = 2'd2, HS_DATA = 2'd3} hs_e;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_SETUP = 2'd1, PH_DATA = 2'd2, PH_STATUS = 2'd3} ph_e;
  typedef enum logic [1:0] {CTX_NONE = 2'd0, CTX_SETUP = 2'd1, CTX_OUT = 2'd2} ctx_e;

  localparam logic [7:0] A_SETUP  = 8'h80;
  localparam logic [7:0] A_IRQ    = 8'h88;
  localparam logic [7:0] A_CTRL   = 8'h89;
  localparam logic [7:0] A_INCNT  = 8'h8A;
  localparam logic [7:0] A_INVAL  = 8'h8B;
  localparam logic [7:0] A_OUTVAL = 8'h8C;
  localparam logic [7:0] A_STAT   = 8'h8D;
  localparam logic [7:0] A_OUTCNT = 8'h8E;

  // A data packet closes the stage when it is short or the requested length is reached.
  function automatic logic stage_last(input logic [15:0] done, input logic [15:0] n,
                                      input logic [15:0] wlen, input int max_pkt);
    return (32'(n) < max_pkt) || (({1'b0, done} + {1'b0, n}) >= {1'b0, wlen});
  endfunction

  // Status runs IN unless the data stage itself is IN with a non-zero length.
  function automatic logic status_is_in(input logic dir_in, input logic [15:0] wlen);
    return !(dir_in && (wlen != 16'd0));
  endfunction

endpackage

// File: rtl/ep0_data_buf.sv
module ep0_data_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ep0_setup_buf.sv
module ep0_setup_buf #(
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [7:0]        wdata,
  output logic [N-1:0][7:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= '0;
      else if (we && (32'(waddr) == g)) q[g] <= wdata;
    end
  end
endmodule

// File: rtl/ep0_irq_flags.sv
module ep0_irq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  // A hardware set in the same cycle as a clear leaves the flag set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else flags <= (flags & ~clr) | set;
  end
endmodule

// File: rtl/ep0_ctrl_engine.sv
module ep0_ctrl_engine
  import ep0_pkg::*;
#(
  parameter int BUF_BYTES   = 64,
  parameter int SETUP_BYTES = 8,
  parameter int EP_W        = 4,
  localparam int BA = $clog2(BUF_BYTES),
  localparam int CW = BA + 1,
  localparam int SA = $clog2(SETUP_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tok_valid,
  input  logic [1:0]      tok_pid,
  input  logic [EP_W-1:0] tok_ep,
  input  logic            rx_valid,
  input  logic [7:0]      rx_byte,
  input  logic            rx_end,
  input  logic [BA-1:0]   tx_addr,
  output logic [7:0]      tx_byte,
  output logic            hs_valid,
  output logic [1:0]      hs_code,
  output logic [CW-1:0]   tx_len,
  input  logic            reg_wr,
  input  logic [7:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic            irq_setup,
  output logic            irq_data,
  output logic            irq_status
);
  ph_e           phase;
  ctx_e          ctx;
  logic [CW-1:0] rx_cnt, in_cnt, out_cnt;
  logic          out_ok, dir_in, st_in, armed, stalled;
  logic [15:0]   wlen, done;
  logic [7:1]    in_val_hi, out_val_hi;
  logic [SETUP_BYTES-1:0][7:0] su;
  logic [7:0]    out_rd;
  logic [2:0]    flags;

  // Named events for the checker
  logic tok_ep0, setup_tok, in_tok, setup_ok, rx_fin_out;
  logic ev_setup, ev_data, ev_status, consume;
  logic fw_arm, fw_stall;
  logic nx_hs_v;
  hs_e  nx_hs;
  logic [CW-1:0] nx_len;
  logic [15:0]   add_n;
  logic [15:0]   su_len;
  logic [1:0]    phase_w;

  function automatic logic [CW-1:0] clamp_cnt(input logic [7:0] v);
    if (32'(v) > BUF_BYTES) return CW'(BUF_BYTES);
    return v[CW-1:0];
  endfunction

  assign tok_ep0    = tok_valid && (tok_ep == '0);
  assign setup_tok  = tok_ep0 && (tok_pid == PID_SETUP);
  assign in_tok     = tok_ep0 && (tok_pid == PID_IN);
  assign setup_ok   = rx_end && (ctx == CTX_SETUP) && (32'(rx_cnt) == SETUP_BYTES);
  assign rx_fin_out = rx_end && (ctx == CTX_OUT);
  assign fw_arm     = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];
  assign fw_stall   = reg_wr && (reg_addr == A_CTRL) && reg_wdata[1];
  assign su_len     = {su[7], su[6]};
  assign ev_setup   = setup_ok;
  assign phase_w    = phase;

  always_comb begin
    nx_hs_v = 1'b0; nx_hs = HS_NAK; nx_len = '0;
    ev_data = 1'b0; ev_status = 1'b0; consume = 1'b0; add_n = '0;
    if (in_tok) begin
      nx_hs_v = 1'b1;
      if (stalled) nx_hs = HS_STALL;
      else if (armed && phase == PH_DATA && dir_in) begin
        nx_hs = HS_DATA; nx_len = in_cnt; consume = 1'b1; add_n = 16'(in_cnt);
        ev_data = stage_last(done, 16'(in_cnt), wlen, BUF_BYTES);
      end else if (armed && phase == PH_STATUS && st_in) begin
        nx_hs = HS_DATA; consume = 1'b1; ev_status = 1'b1;
      end
    end else if (rx_fin_out) begin
      nx_hs_v = 1'b1;
      if (stalled) nx_hs = HS_STALL;
      else if (out_ok && phase == PH_DATA && !dir_in) begin
        nx_hs = HS_ACK; consume = 1'b1; add_n = 16'(rx_cnt);
        ev_data = stage_last(done, 16'(rx_cnt), wlen, BUF_BYTES);
      end else if (out_ok && phase == PH_STATUS && !st_in && rx_cnt == '0) begin
        nx_hs = HS_ACK; consume = 1'b1; ev_status = 1'b1;
      end
    end else if (setup_ok) begin
      nx_hs_v = 1'b1; nx_hs = HS_ACK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; ctx <= CTX_NONE; rx_cnt <= '0; out_ok <= 1'b0;
      dir_in <= 1'b0; st_in <= 1'b1; wlen <= '0; done <= '0;
      armed <= 1'b0; stalled <= 1'b0; in_cnt <= '0; out_cnt <= '0;
      in_val_hi <= '0; out_val_hi <= '0;
      hs_valid <= 1'b0; hs_code <= HS_ACK; tx_len <= '0;
    end else begin
      hs_valid <= nx_hs_v; hs_code <= nx_hs; tx_len <= nx_len;
      if (tok_valid) begin
        ctx    <= !tok_ep0 ? CTX_NONE : (tok_pid == PID_SETUP) ? CTX_SETUP :
                  (tok_pid == PID_OUT) ? CTX_OUT : CTX_NONE;
        rx_cnt <= '0;
        out_ok <= armed && ((phase == PH_DATA && !dir_in) || (phase == PH_STATUS && !st_in));
      end else if (rx_end) begin
        ctx <= CTX_NONE;
      end else if (rx_valid && ctx != CTX_NONE && rx_cnt != '1) begin
        rx_cnt <= rx_cnt + 1'b1;
      end
      if (consume) armed <= 1'b0;
      if (fw_arm) armed <= 1'b1;
      if (fw_stall) stalled <= 1'b1;
      if (setup_tok) begin
        armed <= 1'b0; stalled <= 1'b0; phase <= PH_SETUP;
      end else if (setup_ok) begin
        dir_in <= su[0][7]; wlen <= su_len; done <= '0;
        st_in  <= status_is_in(su[0][7], su_len);
        phase  <= (su_len == 16'd0) ? PH_STATUS : PH_DATA;
      end else if (rx_end && ctx == CTX_SETUP) begin
        phase <= PH_IDLE;
      end else begin
        if (consume && phase == PH_DATA) done <= done + add_n;
        if (ev_data) phase <= PH_STATUS;
        if (ev_status) phase <= PH_IDLE;
      end
      if (rx_fin_out && consume && phase == PH_DATA) out_cnt <= rx_cnt;
      if (reg_wr && reg_addr == A_INCNT) in_cnt <= clamp_cnt(reg_wdata);
      if (reg_wr && reg_addr == A_INVAL) in_val_hi <= reg_wdata[7:1];
      if (reg_wr && reg_addr == A_OUTVAL) out_val_hi <= reg_wdata[7:1];
    end
  end

  ep0_setup_buf #(.N(SETUP_BYTES)) u_setup (
    .clk(clk), .rst_n(rst_n),
    .we(rx_valid && ctx == CTX_SETUP && 32'(rx_cnt) < SETUP_BYTES),
    .waddr(rx_cnt[SA-1:0]), .wdata(rx_byte), .q(su)
  );

  ep0_data_buf #(.DEPTH(BUF_BYTES)) u_inbuf (
    .clk(clk), .rst_n(rst_n),
    .we(reg_wr && 32'(reg_addr) < BUF_BYTES),
    .waddr(reg_addr[BA-1:0]), .wdata(reg_wdata),
    .raddr(tx_addr), .rdata(tx_byte)
  );

  ep0_data_buf #(.DEPTH(BUF_BYTES)) u_outbuf (
    .clk(clk), .rst_n(rst_n),
    .we(rx_valid && ctx == CTX_OUT && out_ok && phase == PH_DATA && 32'(rx_cnt) < BUF_BYTES),
    .waddr(rx_cnt[BA-1:0]), .wdata(rx_byte),
    .raddr(reg_addr[BA-1:0]), .rdata(out_rd)
  );

  ep0_irq_flags #(.N(3)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .set({ev_status, ev_data, ev_setup}),
    .clr((reg_wr && reg_addr == A_IRQ) ? reg_wdata[2:0] : 3'b000),
    .flags(flags)
  );

  assign irq_setup  = flags[0];
  assign irq_data   = flags[1];
  assign irq_status = flags[2];

  always_comb begin
    reg_rdata = '0;
    if (32'(reg_addr) < BUF_BYTES) reg_rdata = '0;
    else if (32'(reg_addr) < 2 * BUF_BYTES) reg_rdata = out_rd;
    else if (reg_addr >= A_SETUP && 32'(reg_addr) < 32'(A_SETUP) + SETUP_BYTES)
      reg_rdata = su[reg_addr[SA-1:0]];
    else begin
      case (reg_addr)
        A_IRQ:    reg_rdata = {5'b0, flags};
        A_CTRL:   reg_rdata = {6'b0, stalled, armed};
        A_INCNT:  reg_rdata = 8'(in_cnt);
        A_INVAL:  reg_rdata = {in_val_hi, 1'b1};
        A_OUTVAL: reg_rdata = {out_val_hi, 1'b1};
        A_STAT:   reg_rdata = {5'b0, dir_in, phase_w};
        A_OUTCNT: reg_rdata = 8'(out_cnt);
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ep0_ctrl_checker.sv
module ep0_ctrl_checker #(
  parameter int EP_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_setup,
  input logic            ev_data,
  input logic            ev_status,
  input logic            irq_setup,
  input logic            irq_data,
  input logic            irq_status,
  input logic            hs_valid,
  input logic [1:0]      hs_code,
  input logic            stalled,
  input logic            tok_valid,
  input logic [EP_W-1:0] tok_ep,
  input logic            reg_wr,
  input logic [7:0]      reg_addr,
  input logic [7:0]      reg_wdata,
  input logic [7:0]      reg_rdata,
  input logic [1:0]      phase
);
  AST_ONE_PHASE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_setup, ev_data, ev_status})); // R3
  AST_OTHER_EP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ep != '0) |=> !hs_valid); // R2
  AST_DATA_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |=> (phase == 2'd3)); // R6
  AST_STATUS_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_status |=> (phase == 2'd0)); // R7
  AST_STALL_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stalled) && hs_valid && !$past(ev_setup)) |-> (hs_code == 2'd2)); // R9
  AST_SETUP_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_setup |=> irq_setup); // R11
  AST_DATA_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |=> irq_data); // R11
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h88 && reg_wdata[0] && !ev_setup) |=> !irq_setup); // R11
  AST_VALID_BIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h8B || reg_addr == 8'h8C) |-> reg_rdata[0]); // R12
endmodule

bind ep0_ctrl_engine ep0_ctrl_checker #(.EP_W(EP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_setup(ev_setup), .ev_data(ev_data), .ev_status(ev_status),
  .irq_setup(irq_setup), .irq_data(irq_data), .irq_status(irq_status),
  .hs_valid(hs_valid), .hs_code(hs_code), .stalled(stalled),
  .tok_valid(tok_valid), .tok_ep(tok_ep), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .phase(phase_w)
);

// File: tb/sim_ep0_ctrl_engine.sv
module sim_ep0_ctrl_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tok_valid = 0, rx_valid = 0, rx_end = 0, reg_wr = 0;
  logic [1:0] tok_pid = 0;
  logic [3:0] tok_ep = 0;
  logic [7:0] rx_byte = 0, reg_addr = 0, reg_wdata = 0;
  logic [5:0] tx_addr = 0;
  logic [7:0] tx_byte, reg_rdata;
  logic hs_valid, irq_setup, irq_data, irq_status;
  logic [1:0] hs_code;
  logic [6:0] tx_len;

  int n_chk = 0, n_fail = 0;
  logic [2:0] m_flags = 3'b000;   // reference model of the sticky flags
  logic hv; logic [1:0] hc; logic [6:0] hl; logic [7:0] rv;

  always #5 clk = ~clk;

  ep0_ctrl_engine u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Flags compared with the model after every clock edge
  always @(negedge clk) if (rst_n) begin
    #1 chk("R11 flag model", {irq_status, irq_data, irq_setup}, m_flags);
  end

  task automatic grab(); hv = hs_valid; hc = hs_code; hl = tx_len; endtask

  task automatic tok(input logic [1:0] pid, input logic [3:0] ep);
    tok_valid = 1; tok_pid = pid; tok_ep = ep;
    @(negedge clk); tok_valid = 0; grab();
  endtask

  task automatic finish_pkt(input bit clr_setup);
    rx_valid = 0; rx_end = 1;
    if (clr_setup) begin reg_wr = 1; reg_addr = 8'h88; reg_wdata = 8'h01; end
    @(negedge clk); rx_end = 0; reg_wr = 0; grab();
  endtask

  task automatic setup8(input logic [63:0] w, input bit clr_setup);
    for (int i = 0; i < 8; i++) begin
      rx_valid = 1; rx_byte = w[8*i +: 8]; @(negedge clk);
    end
    finish_pkt(clr_setup);
  endtask

  task automatic send_seq(input int n, input logic [7:0] start);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_byte = start + 8'(i); @(negedge clk);
    end
    finish_pkt(1'b0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    reg_addr = a; #1 rv = reg_rdata;
  endtask

  task automatic hs(input string tag, input int v, input int c, input int l);
    chk({tag, " hs_valid"}, hv, v);
    if (v != 0) begin
      chk({tag, " hs_code"}, hc, c);
      chk({tag, " tx_len"}, hl, l);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("reset hs_valid", hs_valid, 0);
    rd(8'h8D); chk("R3 reset phase", rv, 8'h00);

    // R12 valid bits
    wr(8'h8B, 8'h00); rd(8'h8B); chk("R12 in valid write 0", rv, 8'h01);
    wr(8'h8B, 8'hA4); rd(8'h8B); chk("R12 in valid upper bits", rv, 8'hA5);
    wr(8'h8C, 8'h00); rd(8'h8C); chk("R12 out valid write 0", rv, 8'h01);

    // R2 other endpoints ignored
    tok(2'd0, 4'd3); setup8(64'h1122334455667788, 0);
    hs("R2 setup ep3", hv, 0, 0); chk("R2 no handshake", hv, 0);
    rd(8'h80); chk("R2 not captured", rv, 8'h00);
    rd(8'h8D); chk("R2 phase idle", rv, 8'h00);
    tok(2'd2, 4'd5); chk("R2 in ep5 silent", hv, 0);

    // R1 IN request, length 100
    tok(2'd0, 4'd0); setup8(64'h0064_0000_0100_0680, 0); m_flags[0] = 1;
    hs("R1 setup ack", 1, 0, 0);
    rd(8'h80); chk("R1 byte0", rv, 8'h80);
    rd(8'h81); chk("R1 byte1", rv, 8'h06);
    rd(8'h86); chk("R1 byte6", rv, 8'h64);
    rd(8'h8D); chk("R3 data phase dir in", rv, 8'h06);

    tok(2'd2, 4'd0); hs("R8 unarmed IN nak", 1, 1, 0);

    // R4 / R6 IN data stage, two packets
    for (int i = 0; i < 64; i++) wr(8'(i), 8'hA0 + 8'(i));
    wr(8'h8A, 8'd64); wr(8'h89, 8'h01);
    tx_addr = 6'd5; #1 chk("R4 tx_byte", tx_byte, 8'hA5);
    tok(2'd2, 4'd0); hs("R4 IN full packet", 1, 3, 64);
    rd(8'h8D); chk("R6 full packet keeps data", rv, 8'h06);
    tok(2'd2, 4'd0); hs("R8 arm consumed", 1, 1, 0);
    wr(8'h8A, 8'd36); wr(8'h89, 8'h01);
    tok(2'd2, 4'd0); m_flags[1] = 1; hs("R4 IN last packet", 1, 3, 36);
    rd(8'h8D); chk("R6 to status", rv, 8'h07);

    wr(8'h88, 8'h01); m_flags[0] = 0;
    rd(8'h88); chk("R11 w1c", rv, 8'h02);

    // R7 status OUT after IN data
    wr(8'h89, 8'h01);
    tok(2'd2, 4'd0); hs("R7 wrong status dir nak", 1, 1, 0);
    tok(2'd1, 4'd0); send_seq(0, 8'h00); m_flags[2] = 1;
    hs("R7 status out ack", 1, 0, 0);
    rd(8'h8D); chk("R7 idle after status", rv, 8'h04);

    // R5 OUT data stage, length 3
    tok(2'd0, 4'd0); setup8(64'h0003_0000_0000_0900, 0); m_flags[0] = 1;
    rd(8'h8D); chk("R3 data phase dir out", rv, 8'h02);
    tok(2'd1, 4'd0); send_seq(3, 8'h11); hs("R8 unarmed OUT nak", 1, 1, 0);
    rd(8'h40); chk("R8 OUT not stored", rv, 8'h00);
    wr(8'h89, 8'h01);
    tok(2'd1, 4'd0); send_seq(3, 8'h11); m_flags[1] = 1;
    hs("R5 OUT ack", 1, 0, 0);
    rd(8'h40); chk("R5 byte0", rv, 8'h11);
    rd(8'h42); chk("R5 byte2", rv, 8'h13);
    rd(8'h8E); chk("R5 count", rv, 8'h03);
    rd(8'h8D); chk("R6 short OUT to status", rv, 8'h03);
    wr(8'h89, 8'h01);
    tok(2'd2, 4'd0); m_flags[2] = 1; hs("R7 status in zlp", 1, 3, 0);
    rd(8'h8D); chk("R7 idle", rv, 8'h00);

    // R3 no-data request, R9 stall
    tok(2'd0, 4'd0); setup8(64'h0000_0000_0000_0500, 0); m_flags[0] = 1;
    rd(8'h8D); chk("R3 zero length to status", rv, 8'h03);
    wr(8'h89, 8'h02);
    tok(2'd2, 4'd0); hs("R9 IN stall", 1, 2, 0);
    tok(2'd1, 4'd0); send_seq(0, 8'h00); hs("R9 OUT stall", 1, 2, 0);
    wr(8'h89, 8'h01);
    tok(2'd2, 4'd0); hs("R9 stall beats arm", 1, 2, 0);

    // R10 new request clears stall, then aborts an armed stage
    tok(2'd0, 4'd0); setup8(64'h0064_0000_0100_0680, 0);
    hs("R10 setup ack while stalled", 1, 0, 0);
    rd(8'h8D); chk("R10 phase data", rv, 8'h06);
    tok(2'd2, 4'd0); hs("R10 stall cleared", 1, 1, 0);
    wr(8'h89, 8'h01);
    tok(2'd0, 4'd0); setup8(64'h0000_0000_0000_0581, 0);
    rd(8'h8D); chk("R10 aborted to status", rv, 8'h07);
    rd(8'h80); chk("R10 buffer overwritten", rv, 8'h81);
    tok(2'd2, 4'd0); hs("R10 arm cleared", 1, 1, 0);

    // R11 set beats clear in the same cycle
    wr(8'h88, 8'h07); m_flags = 3'b000;
    rd(8'h88); chk("R11 all cleared", rv, 8'h00);
    tok(2'd0, 4'd0); setup8(64'h0000_0000_0000_0500, 1); m_flags[0] = 1;
    rd(8'h88); chk("R11 set wins over clear", rv, 8'h01);

    tok(2'd1, 4'd2); send_seq(2, 8'h55); chk("R2 OUT ep2 silent", hv, 0);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule